// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns an arbitrary reference clock into the 16x oversampling enable that a UART's receiver and transmitter run from. A one-cycle reference enable first goes through an integer prescaler that divides by 1 to 7. A phase-accumulating rate multiplier then scales the prescaled rate by (step+1)/(span+1). Both operands are 16-bit register values, so the same block serves reference clocks that are not a neat multiple of the baud rate.

Beside the oversample tick, the block gives a per-bit tick on every sixteenth oversample tick. It also gives a millisecond tick, made by counting prescaled clocks up to a programmed limit. Four 16-bit registers are written and read through a simple port. Serial framing, FIFOs and interrupts belong to neighbouring blocks.

Top module: `frac_baud_gen`

## Requirements
- R1: Starting from a clean phase, after P prescaled clocks the number of oversample ticks is exactly floor(P*(STEP+1)/(SPAN+1)). The phase is a 17-bit accumulator that adds STEP+1 on each prescaled clock and wraps by SPAN+1.
- R2: Register addresses are 0 = STEP, 1 = SPAN, 2 = CTRL and 3 = MSLIM. Each is 16 bits wide. A write takes effect at the clock edge, and rd_data combinationally returns the stored value at rd_addr.
- R3: The prescaler code is CTRL bits 9:7. Code 6 divides by 7, codes 0 to 5 divide by 6 minus the code, and code 7 divides by 1.
- R4: A STEP greater than SPAN acts as STEP equal to SPAN, so there is at most one oversample tick per prescaled clock. Reading STEP still returns the value written.
- R5: CTRL bits outside 9:7 are stored and read back unchanged. They do not affect ticking.
- R6: The ms tick pulses once every MSLIM prescaled clocks. MSLIM = 0 disables it, and a write to MSLIM restarts its count.
- R7: The bit tick is high in the same cycle as every 16th oversample tick counted from a clean phase.
- R8: A write to SPAN clears the phase, the prescaler count and the bit count. No oversample or bit tick appears in the cycle after that write, even when a reference enable arrives in the same cycle.
- R9: After reset, STEP = 0, SPAN = 0, CTRL = 0x0280 (divide by 1), MSLIM = 0, and no tick is asserted.
- R10: Each tick is a single-cycle pulse. It is high in the cycle after the reference-enable cycle that completes a prescaled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference clock enable, one pulse per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data |
| os_tick | output | 1 | 16x oversample tick |
| bit_tick | output | 1 | Per-bit tick |
| ms_tick | output | 1 | Millisecond tick |

## Verification
A write to SPAN and a prescaled clock can fall in the same cycle. In that case the clear must win over the accumulator update. The bench provokes this by holding ref_en high at a 1:1 ratio and divide by 1, so that an oversample tick is due every cycle, and then writing SPAN. The result is judged by requiring os_tick low in the following cycle and high again one cycle later. The bit tick and the oversample tick also coincide by design. That is judged from long-run counts: the bit count must equal the oversample count divided by sixteen.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    parameter int unsigned FBG_DW     = 16;
    parameter int unsigned PSEL_LSB   = 7;
    parameter int unsigned PSEL_W     = 3;
    parameter int unsigned OS_PER_BIT = 16;
    parameter int unsigned MAX_DIV    = 7;

    localparam int unsigned ACC_W = FBG_DW + 1;
    localparam logic [FBG_DW-1:0] CTRL_RST = FBG_DW'(5 << PSEL_LSB);

    typedef enum logic [1:0] {
        REG_STEP  = 2'd0,
        REG_SPAN  = 2'd1,
        REG_CTRL  = 2'd2,
        REG_MSLIM = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [FBG_DW-1:0] step;
        logic [FBG_DW-1:0] span;
        logic [FBG_DW-1:0] ctrl;
        logic [FBG_DW-1:0] mslim;
    } cfg_t;

    // Non-monotonic prescaler code: 6 -> 7, 7 -> 1, else 6 - code.
    function automatic logic [PSEL_W-1:0] psel_to_div(input logic [PSEL_W-1:0] code);
        logic [PSEL_W-1:0] d;
        if (code == PSEL_W'(6))
            d = PSEL_W'(MAX_DIV);
        else if (code == PSEL_W'(7))
            d = PSEL_W'(1);
        else
            d = PSEL_W'(6) - code;
        return d;
    endfunction

    function automatic logic [FBG_DW-1:0] clamp_step(input logic [FBG_DW-1:0] step,
                                                     input logic [FBG_DW-1:0] span);
        return (step > span) ? span : step;
    endfunction

endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [FBG_DW-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [FBG_DW-1:0] rd_data,
    output cfg_t              cfg,
    output logic              span_wr,
    output logic              mslim_wr
);

    reg_addr_e waddr;
    reg_addr_e raddr;

    assign waddr    = reg_addr_e'(wr_addr);
    assign raddr    = reg_addr_e'(rd_addr);
    assign span_wr  = wr_en && (waddr == REG_SPAN);
    assign mslim_wr = wr_en && (waddr == REG_MSLIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.step  <= '0;
            cfg.span  <= '0;
            cfg.ctrl  <= CTRL_RST;
            cfg.mslim <= '0;
        end else if (wr_en) begin
            case (waddr)
                REG_STEP:  cfg.step  <= wr_data;
                REG_SPAN:  cfg.span  <= wr_data;
                REG_CTRL:  cfg.ctrl  <= wr_data;
                REG_MSLIM: cfg.mslim <= wr_data;
                default:   cfg.step  <= cfg.step;
            endcase
        end
    end

    always_comb begin
        case (raddr)
            REG_STEP:  rd_data = cfg.step;
            REG_SPAN:  rd_data = cfg.span;
            REG_CTRL:  rd_data = cfg.ctrl;
            REG_MSLIM: rd_data = cfg.mslim;
            default:   rd_data = '0;
        endcase
    end

    // R2: a written value is what the register holds one cycle later
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && waddr == REG_SPAN) |=> (cfg.span == $past(wr_data)));

endmodule

// File: rtl/fbg_presc.sv
module fbg_presc
    import fbg_pkg::*;
#(
    parameter int unsigned SEL_W = PSEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ref_en,
    input  logic [SEL_W-1:0] sel,
    output logic             pre_tick
);

    logic [SEL_W-1:0] div;
    logic [SEL_W-1:0] cnt_q;
    logic             last;

    assign div      = psel_to_div(sel);
    assign last     = (cnt_q >= (div - SEL_W'(1)));
    assign pre_tick = ref_en && !clr && last;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (ref_en)
            cnt_q <= last ? '0 : cnt_q + SEL_W'(1);
    end

    // R3: the count never reaches the largest divisor
    assert_presc_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < SEL_W'(MAX_DIV));

    // R3: a prescaled clock only comes out of a reference enable
    assert_presc_src_R3: assert property (@(posedge clk) disable iff (rst)
        pre_tick |-> ref_en);

endmodule

// File: rtl/fbg_frac.sv
module fbg_frac
    import fbg_pkg::*;
#(
    parameter int unsigned DW = FBG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          pre_tick,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] span,
    output logic          os_hit,
    output logic          os_tick
);

    localparam int unsigned AW = DW + 1;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] inc;
    logic [AW-1:0] wrap_at;
    logic [AW-1:0] sum;
    logic          wrap;

    assign inc     = {1'b0, clamp_step(step, span)} + AW'(1);
    assign wrap_at = {1'b0, span} + AW'(1);
    assign sum     = acc_q + inc;
    assign wrap    = (sum >= wrap_at);
    assign os_hit  = pre_tick && wrap;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q   <= '0;
            os_tick <= 1'b0;
        end else begin
            if (pre_tick)
                acc_q <= wrap ? (sum - wrap_at) : sum;
            os_tick <= os_hit;
        end
    end

    // R4: the phase stays below the wrap point, so one tick per prescaled clock at most
    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (rst)
        acc_q < wrap_at);

    // R10: an oversample tick follows a prescaled clock by one cycle
    assert_os_src_R10: assert property (@(posedge clk) disable iff (rst)
        os_tick |-> $past(pre_tick));

endmodule

// File: rtl/fbg_bitcnt.sv
module fbg_bitcnt
    import fbg_pkg::*;
#(
    parameter int unsigned N = OS_PER_BIT
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic os_hit,
    output logic bit_tick
);

    generate
        if (N == 1) begin : g_pass
            always_ff @(posedge clk) begin
                if (rst || clr)
                    bit_tick <= 1'b0;
                else
                    bit_tick <= os_hit;
            end
        end else begin : g_count
            localparam int unsigned CW = $clog2(N);
            logic [CW-1:0] cnt_q;
            logic          last;

            assign last = (cnt_q == CW'(N - 1));

            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    cnt_q    <= '0;
                    bit_tick <= 1'b0;
                end else begin
                    if (os_hit)
                        cnt_q <= last ? '0 : cnt_q + CW'(1);
                    bit_tick <= os_hit && last;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fbg_ms.sv
module fbg_ms
    import fbg_pkg::*;
#(
    parameter int unsigned DW = FBG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          pre_tick,
    input  logic [DW-1:0] limit,
    output logic          ms_tick
);

    logic [DW-1:0] cnt_q;
    logic          armed;
    logic          hit;

    assign armed = (limit != '0);
    assign hit   = pre_tick && armed && (cnt_q >= (limit - DW'(1)));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            ms_tick <= 1'b0;
        end else begin
            if (pre_tick && armed)
                cnt_q <= hit ? '0 : cnt_q + DW'(1);
            ms_tick <= hit;
        end
    end

    // R6: a zero limit never yields a tick
    assert_ms_off_R6: assert property (@(posedge clk) disable iff (rst)
        ms_tick |-> ($past(limit) != '0));

    // R6: the count stays under the limit while enabled
    assert_ms_bound_R6: assert property (@(posedge clk) disable iff (rst)
        armed |-> (cnt_q < limit));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        os_tick,
    output logic        bit_tick,
    output logic        ms_tick
);

    cfg_t cfg;
    logic span_wr;
    logic mslim_wr;
    logic pre_tick;
    logic os_hit;

    fbg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg      (cfg),
        .span_wr  (span_wr),
        .mslim_wr (mslim_wr)
    );

    fbg_presc #(.SEL_W(PSEL_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .clr      (span_wr),
        .ref_en   (ref_en),
        .sel      (cfg.ctrl[PSEL_LSB +: PSEL_W]),
        .pre_tick (pre_tick)
    );

    fbg_frac #(.DW(FBG_DW)) u_frac (
        .clk      (clk),
        .rst      (rst),
        .clr      (span_wr),
        .pre_tick (pre_tick),
        .step     (cfg.step),
        .span     (cfg.span),
        .os_hit   (os_hit),
        .os_tick  (os_tick)
    );

    fbg_bitcnt #(.N(OS_PER_BIT)) u_bitcnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (span_wr),
        .os_hit   (os_hit),
        .bit_tick (bit_tick)
    );

    fbg_ms #(.DW(FBG_DW)) u_ms (
        .clk      (clk),
        .rst      (rst),
        .clr      (mslim_wr),
        .pre_tick (pre_tick),
        .limit    (cfg.mslim),
        .ms_tick  (ms_tick)
    );

    // R7: a bit tick always rides on an oversample tick
    assert_bit_on_os_R7: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick);

    // R8: the cycle after a span write is quiet
    assert_clear_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        $past(span_wr) |-> (!os_tick && !bit_tick));

endmodule

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        ref_en;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic        os_tick;
    logic        bit_tick;
    logic        ms_tick;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    bit          cnt_on = 1'b0;
    longint      c_os   = 0;
    longint      c_bit  = 0;
    longint      c_ms   = 0;

    always #10 clk = ~clk;

    frac_baud_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .ref_en   (ref_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .os_tick  (os_tick),
        .bit_tick (bit_tick),
        .ms_tick  (ms_tick)
    );

    always @(negedge clk) begin
        if (cnt_on) begin
            c_os  += longint'(os_tick);
            c_bit += longint'(bit_tick);
            c_ms  += longint'(ms_tick);
        end
    end

    function automatic longint div_of(input int code);
        if (code == 6) return 7;
        if (code == 7) return 1;
        return longint'(6 - code);
    endfunction

    function automatic longint exp_os(input longint p, input longint s, input longint m);
        longint se;
        se = (s > m) ? m : s;
        return (p * (se + 1)) / (m + 1);
    endfunction

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_tol(input string req, input longint got, input longint exp);
        longint d;
        n_chk++;
        d = got - exp;
        if (d > 1 || d < -1) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (+-1)", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Program a configuration, then run n cycles of enables at prob percent.
    task automatic run_cfg(input string tag, input int s, input int m, input int code,
                           input logic [15:0] upper, input int ms, input int n, input int prob);
        longint e;
        longint p;
        e = 0;
        wr(2'd2, (upper & 16'hFC7F) | 16'((code & 7) << 7));
        wr(2'd0, 16'(s));
        wr(2'd3, 16'(ms));
        wr(2'd1, 16'(m));
        c_os = 0; c_bit = 0; c_ms = 0;
        cnt_on = 1'b1;
        for (int i = 0; i < n; i++) begin
            ref_en = (($urandom % 100) < prob);
            if (ref_en) e++;
            @(negedge clk);
        end
        ref_en = 1'b0;
        repeat (3) @(negedge clk);
        cnt_on = 1'b0;
        p = e / div_of(code);
        chk_tol({tag, " R1 oversample count"}, c_os, exp_os(p, s, m));
        chk_tol({tag, " R7 bit count"}, c_bit, exp_os(p, s, m) / 16);
        chk_tol({tag, " R6 ms count"}, c_ms, (ms == 0) ? 0 : p / ms);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        rst = 1'b1; ref_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(2'd0, v); chk("R9 STEP reset", v, 0);
        rd(2'd1, v); chk("R9 SPAN reset", v, 0);
        rd(2'd2, v); chk("R9 CTRL reset", v, 16'h0280);
        rd(2'd3, v); chk("R9 MSLIM reset", v, 0);
        chk("R9 ticks idle", {os_tick, bit_tick, ms_tick}, 0);

        // R10 single pulse latency at reset defaults (divide 1, 1:1)
        ref_en = 1'b1;
        @(negedge clk);
        ref_en = 1'b0;
        chk("R10 os tick one cycle later", os_tick, 1);
        @(negedge clk);
        chk("R10 os tick single cycle", os_tick, 0);

        // R8 clear collides with a prescaled clock
        ref_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 os every cycle before clear", os_tick, 1);
        wr(2'd1, 16'd0);
        chk("R8 quiet after span write", os_tick, 0);
        @(negedge clk);
        chk("R8 ticking resumes", os_tick, 1);
        ref_en = 1'b0;
        @(negedge clk);

        // R2 / R5 register readback, other CTRL bits preserved
        wr(2'd2, 16'hFEFF);
        rd(2'd2, v); chk("R5 CTRL readback", v, 16'hFEFF);
        wr(2'd0, 16'h1234);
        rd(2'd0, v); chk("R2 STEP readback", v, 16'h1234);
        wr(2'd3, 16'hBEEF);
        rd(2'd3, v); chk("R2 MSLIM readback", v, 16'hBEEF);

        // R3 prescaler decode, full enable rate, 1:1
        run_cfg("R3 code0", 0, 0, 0, 16'h0000, 0, 420, 100);
        run_cfg("R3 code6", 0, 0, 6, 16'h0000, 0, 420, 100);
        run_cfg("R3 code7", 0, 0, 7, 16'h0000, 0, 420, 100);
        run_cfg("R3 code5 R5 upper bits", 0, 0, 5, 16'hFC7F, 0, 420, 100);

        // R4 step above span saturates
        run_cfg("R4 clamp", 300, 9, 5, 16'h0000, 0, 400, 100);
        rd(2'd0, v); chk("R4 STEP raw readback", v, 300);

        // R6 disabled and enabled ms
        run_cfg("R6 ms off", 3, 7, 5, 16'h0000, 0, 500, 100);
        run_cfg("R6 ms 25", 3, 7, 4, 16'h0000, 25, 800, 70);

        // R1 exact-ratio cases
        run_cfg("R1 1of3", 0, 2, 5, 16'h0000, 0, 900, 100);
        run_cfg("R1 wide", 4999, 59999, 1, 16'h0000, 10, 3000, 100);

        // Random configurations
        for (int k = 0; k < 10; k++) begin
            int m;
            int s;
            m = int'($urandom % 1000);
            s = ((($urandom % 8) == 0)) ? m + int'($urandom % 50) + 1 : int'($urandom % (m + 1));
            run_cfg("R1 random", s, m, int'($urandom % 8), 16'($urandom), int'($urandom % 40),
                    2500, 30 + int'($urandom % 70));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule